// File: doc/BRIEF.md
# Logical Shift Unit with Condition Flags

This block is the shift execution unit of a small integer datapath. It moves a 32-bit operand left or right by a count of 0 to 31 positions. Bits that move out of the word are lost, and the vacated positions are filled with zeros. The count comes from one of two sources. The first is a 5-bit immediate taken from the instruction. The second is a general register, of which only the low five bits are used. Along with the shifted word the unit reports four condition flags: carry, overflow, sign and zero. The pipeline can write these flags into its status word.

The shift network is combinational. It is built from log2(width) conditional stages and computes both directions with a single right-shifting network, reversing the bits on the way in and on the way out for a left shift. The carry flag falls out of one extra guard bit carried through the stages. A thin registered stage captures the result and the flags on each accepted operation and holds them until the next one. The parameter `STAGED` selects between the explicit stage network and a plain operator form of the same function.

Top module: `shift_flag_unit`

## Requirements
- R1: With `cnt_from_reg`=0 the count is `imm_cnt` zero-extended, so every count from 0 to 31 is reachable.
- R2: With `cnt_from_reg`=1 the count is `reg_cnt[4:0]`, and bits 31..5 of `reg_cnt` have no effect on any output.
- R3: With `dir_right`=1 the result is the operand shifted right by the count, with zeros entering at bit 31.
- R4: With `dir_right`=0 the result is the operand shifted left by the count, with zeros entering at bit 0.
- R5: `flag_ov` is 0 after every operation.
- R6: `flag_cy` is the last bit shifted out. That is operand bit (32-n) for a left shift by n, or operand bit (n-1) for a right shift by n, and 0 when n is 0.
- R7: `flag_s` equals bit 31 of the result.
- R8: `flag_z` is 1 exactly when all 32 result bits are 0.
- R9: A count of 0 returns the operand unchanged in either direction.
- R10: An operation presented with `in_valid`=1 appears on the outputs after one rising clock edge, with `out_valid`=1. With `in_valid`=0 the result and flags hold their values and `out_valid` is 0. Reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Accept an operation this cycle |
| operand | input | 32 | Word to be shifted |
| imm_cnt | input | 5 | Immediate shift count |
| reg_cnt | input | 32 | Register value supplying the count (low 5 bits used) |
| cnt_from_reg | input | 1 | 1: count from `reg_cnt`, 0: count from `imm_cnt` |
| dir_right | input | 1 | 1: shift right, 0: shift left |
| out_valid | output | 1 | Result and flags updated on the last edge |
| result | output | 32 | Shifted word |
| flag_cy | output | 1 | Carry: last bit shifted out |
| flag_ov | output | 1 | Overflow, always cleared |
| flag_s | output | 1 | Sign: bit 31 of result |
| flag_z | output | 1 | Zero: result is all zeros |

## Verification
The carry flag is the hardest case to reach from the ports. It samples a different operand bit for every count and direction, and at the extreme counts it reads bit 0 or bit 31 of the operand. The stimulus sweeps every count in both directions and through both count sources. It uses operands with single isolated set bits and alternating patterns, so that a carry taken from a neighbouring bit gives a different value. Register-sourced counts carry noisy upper bits that change on every vector, so any use of bits above 4 shows up as a wrong result.

// File: rtl/sfu_pkg.sv
package sfu_pkg;
   localparam int unsigned SFU_DATA_W = 32;
   localparam int unsigned SFU_CNT_W  = $clog2(SFU_DATA_W);

   typedef struct packed {
      logic cy;
      logic ov;
      logic s;
      logic z;
   } sfu_flags_t;
endpackage

// File: rtl/sfu_count_sel.sv
module sfu_count_sel #(
   parameter int unsigned CNT_W = 5,
   parameter int unsigned REG_W = 32
) (
   input  logic [CNT_W-1:0] imm_cnt,
   input  logic [REG_W-1:0] reg_cnt,
   input  logic             from_reg,
   output logic [CNT_W-1:0] cnt
);
   generate
      if (REG_W < CNT_W) begin : g_bad_width
         $error("sfu_count_sel: REG_W must be at least CNT_W");
      end
   endgenerate

   always_comb begin
      if (from_reg) cnt = reg_cnt[CNT_W-1:0];
      else          cnt = imm_cnt;
   end
endmodule

// File: rtl/sfu_barrel.sv
module sfu_barrel #(
   parameter int unsigned DATA_W = 32,
   parameter bit          STAGED = 1'b1,
   localparam int unsigned CNT_W = $clog2(DATA_W),
   localparam int unsigned EXT_W = DATA_W + 1
) (
   input  logic [DATA_W-1:0] data_in,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              dir_right,
   output logic [DATA_W-1:0] data_out,
   output logic              carry_out
);
   logic [DATA_W-1:0] src;
   logic [EXT_W-1:0]  shifted;
   logic [DATA_W-1:0] body;

   // Left shifts reuse the right network on bit-reversed data.
   always_comb begin
      for (int i = 0; i < DATA_W; i++) begin
         src[i] = dir_right ? data_in[i] : data_in[DATA_W-1-i];
      end
   end

   generate
      if (STAGED) begin : g_staged
         logic [CNT_W:0][EXT_W-1:0] st;
         assign st[0] = {src, 1'b0};
         for (genvar k = 0; k < CNT_W; k++) begin : g_stage
            assign st[k+1] = cnt[k] ? (st[k] >> (2 ** k)) : st[k];
         end
         assign shifted = st[CNT_W];
      end else begin : g_operator
         assign shifted = {src, 1'b0} >> cnt;
      end
   endgenerate

   assign body      = shifted[EXT_W-1:1];
   assign carry_out = shifted[0];

   always_comb begin
      for (int i = 0; i < DATA_W; i++) begin
         data_out[i] = dir_right ? body[i] : body[DATA_W-1-i];
      end
   end
endmodule

// File: rtl/sfu_flag_gen.sv
module sfu_flag_gen
   import sfu_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic [DATA_W-1:0] res,
   input  logic              carry_in,
   output sfu_flags_t        flags
);
   always_comb begin
      flags.cy = carry_in;
      flags.ov = 1'b0;
      flags.s  = res[DATA_W-1];
      flags.z  = (res == '0);
   end
endmodule

// File: rtl/shift_flag_unit.sv
module shift_flag_unit
   import sfu_pkg::*;
#(
   parameter int unsigned DATA_W = SFU_DATA_W,
   parameter int unsigned REG_W  = SFU_DATA_W,
   parameter bit          STAGED = 1'b1,
   localparam int unsigned CNT_W = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] operand,
   input  logic [CNT_W-1:0]  imm_cnt,
   input  logic [REG_W-1:0]  reg_cnt,
   input  logic              cnt_from_reg,
   input  logic              dir_right,
   output logic              out_valid,
   output logic [DATA_W-1:0] result,
   output logic              flag_cy,
   output logic              flag_ov,
   output logic              flag_s,
   output logic              flag_z
);
   generate
      if ((DATA_W < 2) || ((DATA_W & (DATA_W - 1)) != 0)) begin : g_bad_data_w
         $error("shift_flag_unit: DATA_W must be a power of two");
      end
   endgenerate

   logic [CNT_W-1:0]  cnt_eff;
   logic [DATA_W-1:0] sh_res;
   logic              sh_cy;
   sfu_flags_t        flg_nxt;
   sfu_flags_t        flg_q;

   sfu_count_sel #(.CNT_W(CNT_W), .REG_W(REG_W)) u_cnt (
      .imm_cnt (imm_cnt),
      .reg_cnt (reg_cnt),
      .from_reg(cnt_from_reg),
      .cnt     (cnt_eff)
   );

   sfu_barrel #(.DATA_W(DATA_W), .STAGED(STAGED)) u_shift (
      .data_in  (operand),
      .cnt      (cnt_eff),
      .dir_right(dir_right),
      .data_out (sh_res),
      .carry_out(sh_cy)
   );

   sfu_flag_gen #(.DATA_W(DATA_W)) u_flags (
      .res     (sh_res),
      .carry_in(sh_cy),
      .flags   (flg_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
         flg_q     <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            result <= sh_res;
            flg_q  <= flg_nxt;
         end
      end
   end

   assign flag_cy = flg_q.cy;
   assign flag_ov = flg_q.ov;
   assign flag_s  = flg_q.s;
   assign flag_z  = flg_q.z;
endmodule

// File: rtl/shift_flag_unit_checker.sv
module shift_flag_unit_checker #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned REG_W  = 32,
   localparam int unsigned CNT_W = $clog2(DATA_W)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [DATA_W-1:0] operand,
   input logic [CNT_W-1:0]  imm_cnt,
   input logic [REG_W-1:0]  reg_cnt,
   input logic              cnt_from_reg,
   input logic              dir_right,
   input logic              out_valid,
   input logic [DATA_W-1:0] result,
   input logic              flag_cy,
   input logic              flag_ov,
   input logic              flag_s,
   input logic              flag_z
);
   logic [CNT_W-1:0] n_port;
   assign n_port = cnt_from_reg ? reg_cnt[CNT_W-1:0] : imm_cnt;

   assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (flag_ov == 1'b0));

   assert_zero_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (flag_z == (result == '0)));

   assert_sign_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (flag_s == result[DATA_W-1]));

   assert_pass_through_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (n_port == '0)) |=> (result == $past(operand)) && !flag_cy);

   assert_right_zero_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && dir_right && (n_port != '0))
         |=> ((result >> (DATA_W - 32'($past(n_port)))) == '0));

   assert_left_zero_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !dir_right && (n_port != '0))
         |=> ((result << (DATA_W - 32'($past(n_port)))) == '0));

   assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(result) && $stable(flag_cy)
                     && $stable(flag_s) && $stable(flag_z)));
endmodule

bind shift_flag_unit shift_flag_unit_checker #(.DATA_W(DATA_W), .REG_W(REG_W)) u_chk (.*);

// File: tb/shift_flag_unit_bench.sv
module shift_flag_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] operand = '0;
   logic [4:0]  imm_cnt = '0;
   logic [31:0] reg_cnt = '0;
   logic        cnt_from_reg = 1'b0;
   logic        dir_right = 1'b0;
   logic        out_valid;
   logic [31:0] result;
   logic        flag_cy, flag_ov, flag_s, flag_z;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   shift_flag_unit u_shift_flag_unit (.*);

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic run_op(input logic [31:0] op, input int n, input bit right,
                         input bit use_reg, input logic [26:0] noise);
      logic [31:0] exp_res;
      logic        exp_cy;
      string       st;
      @(negedge clk);
      operand      = op;
      dir_right    = right;
      cnt_from_reg = use_reg;
      if (use_reg) begin
         reg_cnt = {noise, 5'(n)};
         imm_cnt = 5'(~n);
      end else begin
         imm_cnt = 5'(n);
         reg_cnt = {noise, 5'(~n)};
      end
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      exp_res = right ? (op >> n) : (op << n);
      if (n == 0)      exp_cy = 1'b0;
      else if (right)  exp_cy = op[n-1];
      else             exp_cy = op[32-n];
      st = use_reg ? "R2" : "R1";
      if (n == 0)     chk({"R9 ", st}, result, op);
      else if (right) chk({"R3 ", st}, result, exp_res);
      else            chk({"R4 ", st}, result, exp_res);
      chk("R6 carry", 32'(flag_cy), 32'(exp_cy));
      chk("R5 overflow", 32'(flag_ov), 32'd0);
      chk("R7 sign", 32'(flag_s), 32'(exp_res[31]));
      chk("R8 zero", 32'(flag_z), 32'(exp_res == 32'd0));
      chk("R10 valid", 32'(out_valid), 32'd1);
   endtask

   initial begin
      logic [31:0] pats [8];
      logic [31:0] lfsr;
      logic [31:0] held;
      pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF;
      pats[2] = 32'h8000_0001; pats[3] = 32'hA5A5_5A5A;
      pats[4] = 32'h0000_0001; pats[5] = 32'h8000_0000;
      pats[6] = 32'h7FFF_FFFE; pats[7] = 32'h1234_5678;
      lfsr = 32'hACE1_2468;
      repeat (3) @(negedge clk);
      // R10: reset state
      chk("R10 reset valid", 32'(out_valid), 32'd0);
      chk("R10 reset result", result, 32'd0);
      chk("R10 reset flags", {28'd0, flag_cy, flag_ov, flag_s, flag_z}, 32'd0);
      rst_n = 1'b1;
      for (int p = 0; p < 8; p++) begin
         for (int n = 0; n < 32; n++) begin
            for (int d = 0; d < 2; d++) begin
               for (int r = 0; r < 2; r++) begin
                  lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                  run_op(pats[p], n, d[0], r[0], lfsr[26:0]);
               end
            end
         end
      end
      // R10: idle cycles hold the last result
      run_op(32'h0F0F_0001, 4, 1'b1, 1'b0, 27'd0);
      held = result;
      @(negedge clk);
      operand = 32'hDEAD_BEEF; imm_cnt = 5'd0; dir_right = 1'b0;
      @(negedge clk);
      chk("R10 hold result", result, held);
      chk("R10 hold valid", 32'(out_valid), 32'd0);
      chk("R10 hold carry", 32'(flag_cy), 32'd0);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule